// File: doc/BRIEF.md
# Five-Port Store-and-Forward Mesh Router

This block is one node of a two-dimensional mesh. It has four neighbour ports (north, east, south, west) and one port facing the local processing element. Each port carries 32-bit words and a request/acknowledge handshake in each direction. The router serves a single transfer at a time. It acknowledges one requester, takes in a whole five-word message, and picks an output port from the header using dimension-order (X first, then Y) routing. It rewrites the header's remaining hop count and then hands the message to the chosen output.

A message is five words, header first. The header holds a signed X hop count in bits [7:0] and a signed Y hop count in bits [15:8], both in two's complement. Bits [31:16] carry through untouched. Port indices are 0 = local, 1 = north, 2 = east, 3 = south, 4 = west.

Handshake: a sender raises its request and holds it. The router answers with a one-cycle acknowledge. The router captures the five words on the five rising edges that follow the acknowledge cycle, and the sender then drops its request. On the output side the router holds its request to one port and shows the current word on that port's data lines. It takes a one-cycle acknowledge at a rising edge as proof that the word shown at that edge was taken. It then presents each of the remaining four words for one cycle.

Top module: `mesh_xy_router`

## Requirements
- R1: After reset no acknowledge and no output request is asserted.
- R2: The router acknowledges an input only while idle. At most one input acknowledge and at most one output request are high at any time, and never both together.
- R3: When several inputs request in the same idle cycle, the grant goes to the lowest port index: local (0), then north (1), east (2), south (3), west (4).
- R4: The five words are captured on the five rising edges after the acknowledge cycle, and no output request is raised before all five are stored.
- R5: A header with a nonzero X count leaves on east (2) if X is positive or west (4) if X is negative, whatever Y holds. Its X count moves one step toward zero.
- R6: A header with X equal to zero and a nonzero Y count leaves on north (1) if Y is positive or south (3) if Y is negative. Its Y count moves one step toward zero.
- R7: A header with both counts zero leaves on the local port (0) unchanged.
- R8: Header bits [31:16], the count that is not stepped, and the four payload words leave unchanged and in their original order. The extreme count -128 (0x80) steps to -127 (0x81).
- R9: The output request and the word shown stay stable until the downstream acknowledge arrives, however long that takes.
- R10: The input acknowledge is a single-cycle pulse. A requester that arrives during a transfer is not acknowledged until the previous message has fully left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_req | input | 5 | Request per input port, held by the sender |
| in_data | input | 5x32 | Word per input port |
| in_ack | output | 5 | One-cycle acknowledge per input port |
| out_req | output | 5 | Request per output port, held until the message is sent |
| out_data | output | 5x32 | Word per output port, zero on ports not in use |
| out_ack | input | 5 | One-cycle acknowledge per output port from downstream |

## Verification
The assertions assume that a sender holds its request until it has been acknowledged, and drops it once its five words have gone. They also assume that the downstream side pulses its acknowledge for one cycle only, and only on the port whose request is high. The stability check of R9 further assumes that no acknowledge arrives on any port that is not requested. The bench keeps to these rules by driving each input port from a task that follows the handshake exactly. A single sink process acknowledges only the port it finds requesting, optionally after a wait of several cycles.

// File: rtl/mesh_rt_pkg.sv
package mesh_rt_pkg;

    typedef enum logic [2:0] {
        PORT_LOCAL = 3'd0,
        PORT_NORTH = 3'd1,
        PORT_EAST  = 3'd2,
        PORT_SOUTH = 3'd3,
        PORT_WEST  = 3'd4
    } port_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_ROUTE,
        ST_WAIT,
        ST_SEND
    } rt_state_e;

endpackage

// File: rtl/mrt_prio_arb.sv
module mrt_prio_arb #(
    parameter int NPORT = 5,
    localparam int IDX_W = $clog2(NPORT)
) (
    input  logic [NPORT-1:0] req,
    output logic [NPORT-1:0] grant,
    output logic [IDX_W-1:0] grant_idx,
    output logic             any
);
    // lowest index wins
    always_comb begin
        grant     = '0;
        grant_idx = '0;
        any       = 1'b0;
        for (int i = NPORT - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant     = '0;
                grant[i]  = 1'b1;
                grant_idx = IDX_W'(i);
                any       = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mrt_xy_step.sv
module mrt_xy_step #(
    parameter int DATA_W = 32,
    parameter int HOP_W  = 8
) (
    input  logic [DATA_W-1:0] hdr_in,
    output mesh_rt_pkg::port_e port,
    output logic [DATA_W-1:0] hdr_out
);
    import mesh_rt_pkg::*;

    logic signed [HOP_W-1:0] x_hops;
    logic signed [HOP_W-1:0] y_hops;

    always_comb begin
        x_hops  = hdr_in[HOP_W-1:0];
        y_hops  = hdr_in[2*HOP_W-1:HOP_W];
        hdr_out = hdr_in;
        port    = PORT_LOCAL;
        if (x_hops != '0) begin
            if (x_hops[HOP_W-1]) begin
                port = PORT_WEST;
                hdr_out[HOP_W-1:0] = x_hops + HOP_W'(1);
            end else begin
                port = PORT_EAST;
                hdr_out[HOP_W-1:0] = x_hops - HOP_W'(1);
            end
        end else if (y_hops != '0) begin
            if (y_hops[HOP_W-1]) begin
                port = PORT_SOUTH;
                hdr_out[2*HOP_W-1:HOP_W] = y_hops + HOP_W'(1);
            end else begin
                port = PORT_NORTH;
                hdr_out[2*HOP_W-1:HOP_W] = y_hops - HOP_W'(1);
            end
        end
    end
endmodule

// File: rtl/mrt_ring_buf.sv
module mrt_ring_buf #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 5,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [PTR_W-1:0]  wr_ptr,
    input  logic              patch_en,
    input  logic [PTR_W-1:0]  patch_idx,
    input  logic [DATA_W-1:0] patch_data,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DEPTH-1:0][DATA_W-1:0] mem_d, mem_q;
    logic [PTR_W-1:0]             wp_d, wp_q;

    always_comb begin
        mem_d = mem_q;
        wp_d  = wp_q;
        if (wr_en) begin
            mem_d[wp_q] = wr_data;
            wp_d = (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + PTR_W'(1);
        end else if (patch_en) begin
            mem_d[patch_idx] = patch_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
            wp_q  <= '0;
        end else begin
            mem_q <= mem_d;
            wp_q  <= wp_d;
        end
    end

    assign wr_ptr  = wp_q;
    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/mesh_xy_router.sv
module mesh_xy_router #(
    parameter int DATA_W    = 32,
    parameter int NPORT     = 5,
    parameter int PKT_WORDS = 5,
    parameter int HOP_W     = 8,
    localparam int PTR_W    = $clog2(PKT_WORDS),
    localparam int IDX_W    = $clog2(NPORT)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPORT-1:0]             in_req,
    input  logic [NPORT-1:0][DATA_W-1:0] in_data,
    output logic [NPORT-1:0]             in_ack,
    output logic [NPORT-1:0]             out_req,
    output logic [NPORT-1:0][DATA_W-1:0] out_data,
    input  logic [NPORT-1:0]             out_ack
);
    import mesh_rt_pkg::*;

    localparam logic [PTR_W-1:0] LAST_W = PTR_W'(PKT_WORDS - 1);

    typedef struct packed {
        rt_state_e        st;
        logic [IDX_W-1:0] src;
        logic [IDX_W-1:0] dst;
        logic [PTR_W-1:0] cnt;
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] rd;
        logic [NPORT-1:0] ack;
    } rt_regs_t;

    rt_regs_t r_d, r_q;

    logic [NPORT-1:0]  grant;
    logic [IDX_W-1:0]  grant_idx;
    logic              grant_any;
    logic              buf_wr, buf_patch;
    logic [DATA_W-1:0] buf_wdata, buf_rdata, new_hdr;
    logic [PTR_W-1:0]  buf_wptr, buf_ridx;
    port_e             route_port;

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_W) ? '0 : p + PTR_W'(1);
    endfunction

    mrt_prio_arb #(.NPORT(NPORT)) u_arb (
        .req       (in_req),
        .grant     (grant),
        .grant_idx (grant_idx),
        .any       (grant_any)
    );

    mrt_ring_buf #(.DATA_W(DATA_W), .DEPTH(PKT_WORDS)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (buf_wr),
        .wr_data    (buf_wdata),
        .wr_ptr     (buf_wptr),
        .patch_en   (buf_patch),
        .patch_idx  (r_q.head),
        .patch_data (new_hdr),
        .rd_idx     (buf_ridx),
        .rd_data    (buf_rdata)
    );

    mrt_xy_step #(.DATA_W(DATA_W), .HOP_W(HOP_W)) u_step (
        .hdr_in  (buf_rdata),
        .port    (route_port),
        .hdr_out (new_hdr)
    );

    always_comb begin
        r_d       = r_q;
        r_d.ack   = '0;
        buf_wr    = 1'b0;
        buf_patch = 1'b0;
        buf_wdata = in_data[r_q.src];
        buf_ridx  = (r_q.st == ST_ROUTE) ? r_q.head : r_q.rd;
        out_req   = '0;
        out_data  = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (grant_any) begin
                    r_d.ack  = grant;
                    r_d.src  = grant_idx;
                    r_d.cnt  = '0;
                    r_d.head = buf_wptr;
                    r_d.st   = ST_RECV;
                end
            end
            ST_RECV: begin
                buf_wr = 1'b1;
                if (r_q.cnt == LAST_W) begin
                    r_d.st = ST_ROUTE;
                end else begin
                    r_d.cnt = r_q.cnt + PTR_W'(1);
                end
            end
            ST_ROUTE: begin
                buf_patch = 1'b1;
                r_d.dst   = IDX_W'(route_port);
                r_d.rd    = r_q.head;
                r_d.st    = ST_WAIT;
            end
            ST_WAIT: begin
                out_req[r_q.dst]  = 1'b1;
                out_data[r_q.dst] = buf_rdata;
                if (out_ack[r_q.dst]) begin
                    r_d.rd  = wrap_inc(r_q.rd);
                    r_d.cnt = PTR_W'(1);
                    r_d.st  = ST_SEND;
                end
            end
            ST_SEND: begin
                out_req[r_q.dst]  = 1'b1;
                out_data[r_q.dst] = buf_rdata;
                r_d.rd = wrap_inc(r_q.rd);
                if (r_q.cnt == LAST_W) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt + PTR_W'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.src  <= '0;
            r_q.dst  <= '0;
            r_q.cnt  <= '0;
            r_q.head <= '0;
            r_q.rd   <= '0;
            r_q.ack  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ack = r_q.ack;
endmodule

// File: rtl/mesh_xy_router_chk.sv
module mesh_xy_router_chk #(
    parameter int DATA_W    = 32,
    parameter int NPORT     = 5,
    parameter int PKT_WORDS = 5
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NPORT-1:0]             in_req,
    input logic [NPORT-1:0]             in_ack,
    input logic [NPORT-1:0]             out_req,
    input logic [NPORT-1:0][DATA_W-1:0] out_data,
    input logic [NPORT-1:0]             out_ack
);
    localparam int CW = $clog2(PKT_WORDS + 1) + 1;

    logic [CW-1:0] fill_q;
    logic          xfer_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
            xfer_q <= 1'b0;
        end else begin
            if (in_ack != '0)       fill_q <= CW'(PKT_WORDS);
            else if (fill_q != '0)  fill_q <= fill_q - CW'(1);
            if (out_req == '0)                 xfer_q <= 1'b0;
            else if ((out_req & out_ack) != '0) xfer_q <= 1'b1;
        end
    end

    assert_ack_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_ack));
    assert_out_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_req));
    assert_ack_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack != '0) |-> (out_req == '0));
    assert_ack_to_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack != '0) |-> ((in_ack & in_req) != '0));
    assert_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack != '0) |-> (((in_ack - NPORT'(1)) & $past(in_req)) == '0));
    assert_store_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q != '0) |-> (out_req == '0));
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_req != '0) && !xfer_q && ((out_req & out_ack) == '0))
        |=> ($stable(out_req) && $stable(out_data)));
    assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack != '0) |=> (in_ack == '0));
endmodule

bind mesh_xy_router mesh_xy_router_chk #(
    .DATA_W(DATA_W), .NPORT(NPORT), .PKT_WORDS(PKT_WORDS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_req   (in_req),
    .in_ack   (in_ack),
    .out_req  (out_req),
    .out_data (out_data),
    .out_ack  (out_ack)
);

// File: tb/mesh_xy_router_test.sv
module mesh_xy_router_test;
    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [4:0]      in_req = '0;
    logic [4:0][31:0] in_data = '0;
    logic [4:0]      in_ack;
    logic [4:0]      out_req;
    logic [4:0][31:0] out_data;
    logic [4:0]      out_ack = '0;

    typedef struct {
        int               port;
        logic [4:0][31:0] w;
        string            tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    int   n_tx = 0;
    int   n_rx = 0;
    int   sink_delay = 0;
    int   ack_rx[5];
    bit   done = 0;

    always #10 clk = ~clk;  // 50 MHz

    mesh_xy_router uut (
        .clk(clk), .rst_n(rst_n),
        .in_req(in_req), .in_data(in_data), .in_ack(in_ack),
        .out_req(out_req), .out_data(out_data), .out_ack(out_ack)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic void xy_model(input logic [31:0] h, output int p,
                                     output logic [31:0] nh);
        logic signed [7:0] x, y;
        x = h[7:0];
        y = h[15:8];
        nh = h;
        if (x > 0)      begin p = 2; nh[7:0] = x - 8'sd1; end
        else if (x < 0) begin p = 4; nh[7:0] = x + 8'sd1; end
        else if (y > 0) begin p = 1; nh[15:8] = y - 8'sd1; end
        else if (y < 0) begin p = 3; nh[15:8] = y + 8'sd1; end
        else p = 0;
    endfunction

    function automatic logic [4:0][31:0] make_pkt(input logic [31:0] hdr,
                                                  input logic [31:0] seed);
        logic [4:0][31:0] w;
        w[0] = hdr;
        for (int i = 1; i < 5; i++) w[i] = seed ^ (32'h0101_0101 * i);
        return w;
    endfunction

    task automatic expect_pkt(input logic [4:0][31:0] w, input string tag);
        exp_t e;
        logic [31:0] nh;
        xy_model(w[0], e.port, nh);
        e.w = w;
        e.w[0] = nh;
        e.tag = tag;
        exp_q.push_back(e);
        n_tx++;
    endtask

    // called at a negedge
    task automatic drive_pkt(input int p, input logic [4:0][31:0] w);
        in_req[p] = 1'b1;
        do @(negedge clk); while (!in_ack[p]);
        ack_rx[p] = n_rx;
        for (int i = 0; i < 5; i++) begin
            in_data[p] = w[i];
            @(negedge clk);
        end
        in_req[p] = 1'b0;
        in_data[p] = '0;
    endtask

    task automatic send(input int p, input logic [31:0] hdr,
                        input logic [31:0] seed, input string tag);
        logic [4:0][31:0] w;
        w = make_pkt(hdr, seed);
        expect_pkt(w, tag);
        drive_pkt(p, w);
    endtask

    // monitor / sink
    initial begin
        forever begin
            @(negedge clk);
            if (out_req != '0) begin
                int d;
                logic [4:0][31:0] got;
                logic [31:0] first;
                exp_t e;
                d = 0;
                for (int i = 0; i < 5; i++) if (out_req[i]) d = i;
                first = out_data[d];
                for (int k = 0; k < sink_delay; k++) begin
                    @(negedge clk);
                    check(out_req[d] && out_data[d] == first, "R9",
                          "held request/word while waiting", out_data[d], first);
                end
                out_ack[d] = 1'b1;
                got[0] = out_data[d];
                for (int i = 1; i < 5; i++) begin
                    @(negedge clk);
                    out_ack[d] = 1'b0;
                    got[i] = out_data[d];
                end
                if (exp_q.size() == 0) begin
                    check(0, "R2", "unexpected output message", d, -1);
                end else begin
                    e = exp_q.pop_front();
                    check(d == e.port, e.tag, "output port", d, e.port);
                    check(got[0] == e.w[0], e.tag, "header word", got[0], e.w[0]);
                    check(got[4:1] == e.w[4:1], "R8", "payload words",
                          got[4:1], e.w[4:1]);
                end
                n_rx++;
            end
        end
    end

    task automatic drain;
        while (n_rx != n_tx) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", n_rx, n_tx);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(in_ack == '0, "R1", "acks after reset", in_ack, 0);
        check(out_req == '0, "R1", "out requests after reset", out_req, 0);

        // R5: positive X with nonzero Y goes east
        send(0, 32'hA5A5_0203, 32'h1111_0000, "R5");
        drain();
        // R5: negative X goes west
        send(1, 32'h0000_05FF, 32'h2222_0000, "R5");
        drain();
        // R6: north
        send(2, 32'h7700_0400, 32'h3333_0000, "R6");
        drain();
        // R6: south
        send(3, 32'h0000_FE00, 32'h4444_0000, "R6");
        drain();
        // R7: local delivery
        send(4, 32'hDEAD_0000, 32'h5555_0000, "R7");
        drain();
        // R8: extreme X count -128
        send(0, 32'h0000_7F80, 32'h6666_0000, "R8");
        drain();

        // R4: word capture after ack, with a long-waiting sink (R9)
        sink_delay = 4;
        send(2, 32'hC0DE_0001, 32'h7777_0000, "R4");
        drain();
        sink_delay = 0;

        // R3: simultaneous requests on north and west; north first
        begin
            logic [4:0][31:0] wn, ww;
            wn = make_pkt(32'h0000_0100, 32'h8888_0000);
            ww = make_pkt(32'h0000_0001, 32'h9999_0000);
            expect_pkt(wn, "R3");
            expect_pkt(ww, "R3");
            fork
                drive_pkt(1, wn);
                drive_pkt(4, ww);
            join
            drain();
            check(ack_rx[1] < ack_rx[4], "R3", "north granted before west",
                  ack_rx[1], ack_rx[4]);
        end

        // R10: a requester arriving mid-transfer waits for the message to leave
        begin
            int base;
            logic [4:0][31:0] wa, wb;
            base = n_rx;
            sink_delay = 3;
            wa = make_pkt(32'h0000_00FD, 32'hAAAA_0000);
            wb = make_pkt(32'h0000_0300, 32'hBBBB_0000);
            expect_pkt(wa, "R10");
            expect_pkt(wb, "R10");
            fork
                drive_pkt(3, wa);
                begin
                    repeat (3) @(negedge clk);
                    drive_pkt(0, wb);
                end
            join
            drain();
            sink_delay = 0;
            check(ack_rx[0] == base + 1, "R10", "late requester acked after first message left",
                  ack_rx[0], base + 1);
        end

        check(exp_q.size() == 0, "R2", "scoreboard empty", exp_q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule